// File: doc/BRIEF.md
# Divided-clock idle wake controller

This block decides when a processor core may leave its low-activity idle state. While the core runs, its clock enable is high on every cycle. An idle request moves the block into one of two idle flavours. In plain idle the clock enable is held low. In divided idle the enable pulses once every n cycles, with n chosen from four power-of-two divisors. The block wakes the core when an enabled interrupt is pending. In divided idle the wake waits for the next divided-clock boundary, so the response time grows with the divisor.

Interrupt requests are latched into a pending vector whether or not they are enabled. A line that is requested several times before it is serviced still holds only one pending flag. The service input clears a pending flag. A request that lands in the same cycle as its service keeps the flag set, so a request raised while the core is slowed is never dropped and never counted twice. The divisor code is captured on the cycle the idle request is accepted and stays fixed for the rest of that idle period.

Top module: `idle_wake_ctrl`

## Requirements
- R1: During and directly after reset the block is running: core_cen is 1, wake is 0, irq_pend is all zeros and the divider count is cleared.
- R2: While running, core_cen is 1 on every cycle. An idle_req sampled with idle_divided=1 enters divided idle with n = 16 << idle_code (code 0=16, 1=32, 2=64, 3=128). core_cen is then 1 only on the n-th cycle after the accepting edge and on every n-th cycle after that.
- R3: A 1 on irq_req[i] sets irq_pend[i] at the next edge, whatever the enable. Repeated requests merge into the one flag. irq_svc[i] clears the flag at the next edge, unless irq_req[i] is also 1 in that cycle, in which case the flag stays set.
- R4: In divided idle, wake and core_cen are both 1 on the first divided-clock pulse at which some line has irq_pend and irq_en both 1. From the next cycle the block is running.
- R5: An idle_req with idle_divided=0 enters plain idle. core_cen stays 0 there until the first cycle in which an enabled line is pending. In that cycle wake and core_cen are 1, and the block runs from the next cycle.
- R6: A pending line whose irq_en bit is 0 causes no wake. If its enable is set later during divided idle, the wake happens at the next divided pulse.
- R7: idle_req is ignored while idle, and so are changes of idle_code during idle. The period chosen at entry is kept.
- R8: wake is a single-cycle pulse. In divided idle it comes no more than n cycles after an enabled pending flag is first visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_req | input | 1 | Request to enter idle, accepted only while running |
| idle_divided | input | 1 | 1 selects divided idle, 0 selects plain idle |
| idle_code | input | 2 | Divisor select, n = 16 << idle_code |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| irq_svc | input | NUM_IRQ | Per-line service acknowledge, clears pending |
| core_cen | output | 1 | Core clock enable |
| wake | output | 1 | One-cycle pulse when idle ends |
| irq_pend | output | NUM_IRQ | Latched pending interrupt flags |

## Verification
On every cycle, the assertions check that the divider count stays inside the selected period and that the captured divisor does not change during idle. They also check that a divided pulse is followed by a quiet cycle, that the state holds through idle, that wake lasts one cycle and is followed by full-rate running, and that pending flags set and hold as they should. The exact position of each pulse for every divisor needs the bench's scenarios, and so do the wake latency from a request arriving mid-period, a masked line waking only after its enable rises, and the merging of repeated requests. A cycle-level model driven by seeded random traffic covers the mixtures of these cases that no single directed test reaches.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

    localparam int DIV_MIN_LOG2 = 4;
    localparam int DIV_CODE_W   = 2;
    localparam int DIV_CNT_W    = DIV_MIN_LOG2 + (1 << DIV_CODE_W) - 1;

    typedef enum logic [1:0] {
        WK_RUN   = 2'd0,
        WK_PLAIN = 2'd1,
        WK_DIV   = 2'd2
    } wake_state_e;

    // last count value of a divided period: (16 << code) - 1
    function automatic logic [DIV_CNT_W-1:0] div_last(input logic [DIV_CODE_W-1:0] code);
        logic [DIV_CNT_W:0] span;
        logic [DIV_CNT_W:0] less;
        span = '0;
        span[DIV_MIN_LOG2 + int'(code)] = 1'b1;
        less = span - 1'b1;
        return less[DIV_CNT_W-1:0];
    endfunction

endpackage

// File: rtl/idle_div_counter.sv
module idle_div_counter
    import idle_wake_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [DIV_CODE_W-1:0] code_in,
    output logic                  tick
);

    typedef struct packed {
        logic [DIV_CNT_W-1:0]  cnt;
        logic [DIV_CODE_W-1:0] code;
    } cnt_reg_t;

    cnt_reg_t             r_d, r_q;
    logic [DIV_CNT_W-1:0] cnt_last;

    always_comb begin
        r_d      = r_q;
        tick     = 1'b0;
        cnt_last = div_last(r_q.code);
        if (load) begin
            r_d.cnt  = '0;
            r_d.code = code_in;
        end else if (step) begin
            if (r_q.cnt == cnt_last) begin
                r_d.cnt = '0;
                tick    = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: the count never leaves the selected period
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= div_last(r_q.code));

    // R7: the captured divisor holds while no load happens
    a_r7_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(r_q.code));

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_svc,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic [NUM_IRQ-1:0] irq_pend,
    output logic               wake_src
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] pend;
    } pend_reg_t;

    pend_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.pend = (r_q.pend & ~irq_svc) | irq_req;
        irq_pend = r_q.pend;
        wake_src = |(r_q.pend & irq_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line_chk
        // R3: a request always leaves its flag set
        a_r3_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |=> r_q.pend[i]);
        // R3: an unserviced flag is never lost
        a_r3_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.pend[i] && !irq_svc[i]) |=> r_q.pend[i]);
        // R3: without a request a flag never appears
        a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!r_q.pend[i] && !irq_req[i]) |=> !r_q.pend[i]);
    end

endmodule

// File: rtl/idle_wake_fsm.sv
module idle_wake_fsm
    import idle_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_req,
    input  logic idle_divided,
    input  logic wake_src,
    input  logic tick,
    output logic cnt_load,
    output logic cnt_step,
    output logic wake,
    output logic core_cen
);

    typedef struct packed {
        wake_state_e state;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        wake     = 1'b0;
        cnt_load = (r_q.state == WK_RUN);
        cnt_step = (r_q.state == WK_DIV);
        unique case (r_q.state)
            WK_RUN: begin
                if (idle_req) begin
                    r_d.state = idle_divided ? WK_DIV : WK_PLAIN;
                end
            end
            WK_PLAIN: begin
                if (wake_src) begin
                    wake      = 1'b1;
                    r_d.state = WK_RUN;
                end
            end
            WK_DIV: begin
                if (tick && wake_src) begin
                    wake      = 1'b1;
                    r_d.state = WK_RUN;
                end
            end
            default: r_d.state = WK_RUN;
        endcase
        core_cen = (r_q.state == WK_RUN) || wake || tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= WK_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    // R8: wake lasts a single cycle
    a_r8_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R4: after a wake the core runs at full rate
    a_r4_resume_run: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> core_cen);

    // R2: a divided pulse that does not wake is followed by a quiet cycle
    a_r2_sparse_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wake) |=> !core_cen);

    // R7: idle persists until a wake, whatever idle_req does
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != WK_RUN && !wake) |=> (r_q.state == $past(r_q.state)));

endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
    import idle_wake_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idle_req,
    input  logic                  idle_divided,
    input  logic [DIV_CODE_W-1:0] idle_code,
    input  logic [NUM_IRQ-1:0]    irq_req,
    input  logic [NUM_IRQ-1:0]    irq_en,
    input  logic [NUM_IRQ-1:0]    irq_svc,
    output logic                  core_cen,
    output logic                  wake,
    output logic [NUM_IRQ-1:0]    irq_pend
);

    logic wake_src;
    logic tick;
    logic cnt_load;
    logic cnt_step;

    irq_pend_latch #(.NUM_IRQ(NUM_IRQ)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .irq_svc  (irq_svc),
        .irq_en   (irq_en),
        .irq_pend (irq_pend),
        .wake_src (wake_src)
    );

    idle_div_counter div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .step    (cnt_step),
        .code_in (idle_code),
        .tick    (tick)
    );

    idle_wake_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_req     (idle_req),
        .idle_divided (idle_divided),
        .wake_src     (wake_src),
        .tick         (tick),
        .cnt_load     (cnt_load),
        .cnt_step     (cnt_step),
        .wake         (wake),
        .core_cen     (core_cen)
    );

    // R6: a wake needs an enabled pending line at the ports
    a_r6_wake_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> |(irq_pend & irq_en));

    // R4: a wake always comes with a clock enable
    a_r4_wake_cen: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> core_cen);

endmodule

// File: tb/idle_wake_ctrl_tb_top.sv
module idle_wake_ctrl_tb_top;

    localparam int NI = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          idle_req;
    logic          idle_divided;
    logic [1:0]    idle_code;
    logic [NI-1:0] irq_req;
    logic [NI-1:0] irq_en;
    logic [NI-1:0] irq_svc;
    logic          core_cen;
    logic          wake;
    logic [NI-1:0] irq_pend;

    int nchk  = 0;
    int nfail = 0;

    // reference model state: 0 run, 1 plain idle, 2 divided idle
    int            mst;
    int            mcnt;
    int            mn;
    logic [NI-1:0] mpend;

    logic          s_cen;
    logic          s_wake;
    logic [NI-1:0] s_pend;

    always #5 clk = ~clk;

    idle_wake_ctrl #(.NUM_IRQ(NI)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_req     (idle_req),
        .idle_divided (idle_divided),
        .idle_code    (idle_code),
        .irq_req      (irq_req),
        .irq_en       (irq_en),
        .irq_svc      (irq_svc),
        .core_cen     (core_cen),
        .wake         (wake),
        .irq_pend     (irq_pend)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_tick();
        return (mst == 2) && (mcnt == mn - 1);
    endfunction

    function automatic bit m_wake();
        bit ep;
        ep = |(mpend & irq_en);
        return ((mst == 1) && ep) || (m_tick() && ep);
    endfunction

    function automatic bit m_cen();
        return (mst == 0) || m_wake() || m_tick();
    endfunction

    // one cycle: sample and compare away from the edge, then advance the model
    task automatic cyc();
        bit    ew;
        string tg;
        #1;
        s_cen  = core_cen;
        s_wake = wake;
        s_pend = irq_pend;
        if (!rst_n) begin
            check("R1 cen", {31'd0, s_cen}, 32'd1);
            check("R1 wake", {31'd0, s_wake}, 32'd0);
            check("R1 pend", {24'd0, s_pend}, 32'd0);
        end else begin
            tg = (mst == 0) ? "R2" : ((mst == 1) ? "R5" : "R4");
            check({tg, " wake"}, {31'd0, s_wake}, {31'd0, m_wake()});
            check({tg, " cen"}, {31'd0, s_cen}, {31'd0, m_cen()});
            check("R3 pend", {24'd0, s_pend}, {24'd0, mpend});
        end
        @(posedge clk);
        if (!rst_n) begin
            mst = 0; mcnt = 0; mn = 16; mpend = '0;
        end else begin
            ew = m_wake();
            if (mst == 0) begin
                if (idle_req) begin
                    mst  = idle_divided ? 2 : 1;
                    mcnt = 0;
                    mn   = 16 << idle_code;
                end
            end else if (ew) begin
                mst  = 0;
                mcnt = 0;
            end else if (mst == 2) begin
                mcnt = (mcnt + 1) % mn;
            end
            mpend = (mpend & ~irq_svc) | irq_req;
        end
        @(negedge clk);
    endtask

    task automatic clear_pend();
        irq_svc = '1;
        cyc();
        irq_svc = '0;
    endtask

    task automatic enter(input bit div, input logic [1:0] code);
        idle_divided = div;
        idle_code    = code;
        idle_req     = 1'b1;
        cyc();
        idle_req     = 1'b0;
    endtask

    // leave idle through line 0; R8 latency bound
    task automatic exit_idle(input int n);
        int j;
        irq_en[0]  = 1'b1;
        irq_req[0] = 1'b1;
        cyc();
        irq_req[0] = 1'b0;
        j = 0;
        for (int k = 1; k <= 300; k++) begin
            cyc();
            if (s_wake) begin
                j = k;
                break;
            end
        end
        check("R8 latency within n", {31'd0, (j >= 1 && j <= n)}, 32'd1);
        clear_pend();
    endtask

    initial begin
        #1_500_000;
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int first, second, wk;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; idle_req = 1'b0; idle_divided = 1'b0; idle_code = '0;
        irq_req = '0; irq_en = '0; irq_svc = '0;
        mst = 0; mcnt = 0; mn = 16; mpend = '0;
        @(negedge clk);
        irq_req = 8'h5A;
        cyc();
        irq_req = '0;
        cyc();
        rst_n = 1'b1;
        cyc();
        check("R1 running after reset", {31'd0, s_cen}, 32'd1);

        // R2: period for each divisor code
        for (int c = 0; c < 4; c++) begin
            int n;
            n = 16 << c;
            irq_en = '0;
            enter(1'b1, c[1:0]);
            first = -1; second = -1;
            for (int k = 1; k <= 2 * n; k++) begin
                cyc();
                if (s_cen) begin
                    if (first < 0) first = k;
                    else if (second < 0) second = k;
                end
            end
            check("R2 first pulse", first, n);
            check("R2 second pulse", second, 2 * n);
            exit_idle(n);
        end

        // R4: divided wake at the boundary after a mid-period request
        irq_en = 8'h04;
        enter(1'b1, 2'd1);
        wk = -1;
        for (int k = 1; k <= 40; k++) begin
            irq_req = (k == 5) ? 8'h04 : 8'h00;
            cyc();
            if (s_wake && wk < 0) wk = k;
        end
        irq_req = '0;
        check("R4 wake on boundary", wk, 32);
        check("R4 running after wake", {31'd0, s_cen}, 32'd1);
        clear_pend();

        // R5: plain idle wakes the cycle after the latch
        irq_en = '1;
        enter(1'b0, 2'd3);
        for (int k = 1; k <= 3; k++) begin
            irq_req = (k == 3) ? 8'h02 : 8'h00;
            cyc();
            check("R5 cen low in plain idle", {31'd0, s_cen}, 32'd0);
        end
        irq_req = '0;
        cyc();
        check("R5 wake", {31'd0, s_wake}, 32'd1);
        check("R5 cen at wake", {31'd0, s_cen}, 32'd1);
        cyc();
        check("R5 running", {31'd0, s_cen}, 32'd1);
        check("R8 pulse ended", {31'd0, s_wake}, 32'd0);
        clear_pend();

        // R6: masked line, enabled later
        irq_en = '0;
        enter(1'b1, 2'd0);
        wk = -1;
        for (int k = 1; k <= 40; k++) begin
            irq_req = (k == 1) ? 8'h04 : 8'h00;
            if (k == 20) irq_en = 8'h04;
            cyc();
            if (s_wake && wk < 0) wk = k;
        end
        irq_req = '0;
        check("R6 masked then enabled wake", wk, 32);
        clear_pend();

        // R7: idle_req and code change ignored while idle
        irq_en = '0;
        enter(1'b1, 2'd0);
        first = -1; second = -1;
        for (int k = 1; k <= 32; k++) begin
            idle_req = (k == 5);
            idle_code = 2'd3;
            idle_divided = (k != 9);
            cyc();
            if (s_cen) begin
                if (first < 0) first = k;
                else if (second < 0) second = k;
            end
        end
        idle_req = 1'b0;
        check("R7 period kept first", first, 16);
        check("R7 period kept second", second, 32);
        exit_idle(16);

        // R3: merging and same-cycle service
        irq_en = '0;
        irq_req = 8'h08; cyc();
        irq_req = 8'h00; cyc();
        irq_req = 8'h08; cyc();
        irq_req = 8'h00; cyc();
        check("R3 merged flag", {24'd0, s_pend}, 32'h08);
        irq_svc = 8'h08; cyc();
        irq_svc = 8'h00; cyc();
        check("R3 single service clears", {24'd0, s_pend}, 32'h00);
        irq_req = 8'h10; cyc();
        irq_req = 8'h10; irq_svc = 8'h10; cyc();
        irq_req = 8'h00; irq_svc = 8'h00; cyc();
        check("R3 request wins over service", {24'd0, s_pend}, 32'h10);
        clear_pend();

        // random traffic against the model
        irq_en = 8'h81;
        for (int i = 0; i < 5000; i++) begin
            idle_req     = ($urandom % 20) == 0;
            idle_divided = ($urandom % 3) != 0;
            idle_code    = 2'($urandom);
            irq_req      = (($urandom % 15) == 0) ? (8'd1 << ($urandom % NI)) : 8'd0;
            irq_svc      = (($urandom % 5) == 0) ? 8'($urandom) : 8'd0;
            if (($urandom % 60) == 0) irq_en = 8'($urandom) | 8'h01;
            cyc();
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule